// File: doc/BRIEF.md
# JESD204B Transport Sample Packer

This block is the transport-layer front end of a JESD204B transmitter. It accepts one converter sample per input transfer and builds the link word for it. The most significant bits of the word are the sample bits. The selected control bits follow. The tail bits fill the remaining low positions, and their count is the word width minus the sample width minus the control-bit count. Tail positions are either zero or filled from a free-running pseudo-random source. A test mode puts a programmed pattern in place of the sample before the word is built.

Each word is cut into octets, most significant octet first. The octets are dealt round-robin across one, two or four lanes. When every active lane holds an octet, the block presents them together as one output beat. Both data interfaces use valid/ready handshakes. An input sample transfers on a clock edge where `in_valid` and `in_ready` are both high. An output beat transfers on an edge where `out_valid` and `out_ready` are both high.

A stalled output beat stays on the pins unchanged, and the stall propagates back until `in_ready` falls. Configuration is static while data flows. After a configuration change, the block is put back in reset. An inconsistent configuration raises `cfg_err` and stops both handshakes.

Top module: `jtp_sample_packer`

## Requirements
- R1: The sample field occupies the N most significant bits of an N'-bit word, MSB first. With N=14, N'=16 and one control bit, the first octet is sample bits 13..6. The second octet is sample bits 5..0, then the control bit, then one tail bit.
- R2: The tail count is T = N' − N − CS. The CS control bits sit directly above the tail, taken from `in_ctrl` starting at bit 2 and going down, so CS=1 uses bit 2 and CS=2 uses bits 2..1.
- R3: With `cfg_tail_en`=0 every tail position is 0. With `cfg_tail_en`=1, tail bit i equals bit i of a 15-bit register that is all ones after reset. On each accepted sample, after its word is built, the register advances to {s[13:0], s[14]^s[13]}.
- R4: With `cfg_test_en`=1 the low N bits of `cfg_test_pat` replace the sample field, and `in_sample` has no effect on the output.
- R5: N' is 16 when `cfg_np16`=1 and 8 otherwise. This gives two or one octets per word, most significant octet first.
- R6: `cfg_lane_sel` values 0, 1 and 2 select 1, 2 and 4 lanes. Lane k is `out_data[8k+7:8k]`. Octets go to lanes 0, 1, and so on in stream order, with lane 0 taking the first octet of every beat. Unused lanes read 0.
- R7: `cfg_err` is 1 exactly when N=0, when N+CS > N', or when `cfg_lane_sel`=3. While it is 1, `in_ready` and `out_valid` are 0.
- R8: Back-pressure: while `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds. No sample is lost or duplicated under any stall pattern.
- R9: When the pipeline is empty and one lane is selected, `out_valid` rises two clock edges after the sample is accepted.
- R10: After reset with a valid configuration, `out_valid`=0, `out_data`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_n | input | 5 | Sample width N (1..16) |
| cfg_np16 | input | 1 | Word width select: 1 = 16 bits, 0 = 8 bits |
| cfg_cs | input | 2 | Control bits per sample (0..3) |
| cfg_lane_sel | input | 2 | Lane count select: 0/1/2 = 1/2/4 lanes |
| cfg_tail_en | input | 1 | Fill tail positions from the pseudo-random source |
| cfg_test_en | input | 1 | Replace samples with the test pattern |
| cfg_test_pat | input | 16 | Test pattern, low N bits used |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken |
| in_sample | input | 16 | Sample, right-aligned |
| in_ctrl | input | 3 | Control bits, bit 2 sent first |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Downstream takes beat |
| out_data | output | 32 | One octet per lane, lane 0 in bits 7:0 |
| cfg_err | output | 1 | Configuration rejected |

## Verification
A sample accepted into an empty pipeline occupies the word stage after one edge. Its first octet lands in the beat on the next edge. With one lane, `out_valid` is therefore seen after the second edge, and the bench probes exactly those two cycles. Otherwise the reference model is transaction-ordered: every input transfer pushes its octets into a queue when the handshake is seen, and every output transfer pops one octet per active lane. Both handshakes are judged one time unit after the inputs change on the falling edge, which is the value the next rising edge acts on. The stall hold is checked from one falling edge to the next.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
  localparam int unsigned P_OCT_W     = 8;
  localparam int unsigned P_WORD_MAX  = 16;
  localparam int unsigned P_LANES_MAX = 4;
  localparam int unsigned P_CTRL_MAX  = 3;
  localparam int unsigned P_PRBS_W    = 15;

  // lane select code to lane count; 0 marks an unsupported code
  function automatic int unsigned lane_count(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/jtp_prbs.sv
module jtp_prbs #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= '1;
    else if (step) state <= {state[W-2:0], state[W-1] ^ state[W-2]};
  end
endmodule

// File: rtl/jtp_word_fmt.sv
module jtp_word_fmt #(
  parameter int unsigned WORD_MAX = 16,
  parameter int unsigned OCT_W    = 8,
  parameter int unsigned CTRL_MAX = 3,
  parameter int unsigned PRBS_W   = 15,
  parameter int unsigned NW       = 5,
  parameter int unsigned CW       = 2
) (
  input  logic [WORD_MAX-1:0] sample,
  input  logic [WORD_MAX-1:0] pat,
  input  logic                test_en,
  input  logic [CTRL_MAX-1:0] ctrl,
  input  logic [NW-1:0]       n,
  input  logic                np16,
  input  logic [CW-1:0]       cs,
  input  logic                tail_en,
  input  logic [PRBS_W-1:0]   prbs,
  output logic [WORD_MAX-1:0] word   // left-aligned in WORD_MAX bits
);
  localparam int unsigned SHW = NW + 1;
  localparam logic [WORD_MAX-1:0] ONES = '1;

  logic [SHW-1:0]      np_v, lead, tail_n;
  logic [WORD_MAX-1:0] s_sel, s_fld, c_fld, t_fld, prbs_ext, raw;

  always_comb begin
    np_v     = np16 ? SHW'(2 * OCT_W) : SHW'(OCT_W);
    lead     = np_v - SHW'(n);
    tail_n   = lead - SHW'(cs);
    s_sel    = test_en ? pat : sample;
    s_fld    = s_sel & ~(ONES << n);
    c_fld    = WORD_MAX'(ctrl >> (CW'(CTRL_MAX) - cs));
    prbs_ext = WORD_MAX'(prbs);
    t_fld    = tail_en ? (prbs_ext & ~(ONES << tail_n)) : '0;
    raw      = (s_fld << lead) | (c_fld << tail_n) | t_fld;
    word     = np16 ? raw : (raw << OCT_W);
  end
endmodule

// File: rtl/jtp_lane_dist.sv
module jtp_lane_dist #(
  parameter int unsigned WORD_MAX  = 16,
  parameter int unsigned OCT_W     = 8,
  parameter int unsigned LANES_MAX = 4,
  parameter int unsigned RW        = $clog2(WORD_MAX / OCT_W + 1),
  parameter int unsigned LCW       = $clog2(LANES_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hold,
  input  logic [RW-1:0]              n_oct,
  input  logic [LCW-1:0]             lanes,
  input  logic                       word_valid,
  output logic                       word_ready,
  input  logic [WORD_MAX-1:0]        word,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [LANES_MAX*OCT_W-1:0] out_data
);
  localparam int unsigned LIW = (LANES_MAX > 1) ? $clog2(LANES_MAX) : 1;

  logic [WORD_MAX-1:0] wreg;
  logic [RW-1:0]       rem;
  logic [LIW-1:0]      fidx, slot;
  logic                bvalid, move, last, take;
  logic [OCT_W-1:0]    beat [LANES_MAX];

  always_comb begin
    move       = (rem != '0) && (!bvalid || out_ready) && !hold;
    slot       = bvalid ? '0 : fidx;
    last       = (LCW'(slot) == lanes - LCW'(1));
    word_ready = !hold && ((rem == '0) || ((rem == RW'(1)) && move));
    take       = word_valid && word_ready;
    out_valid  = bvalid && !hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wreg <= '0;
      rem  <= '0;
    end else if (take) begin
      wreg <= word;
      rem  <= n_oct;
    end else if (move) begin
      wreg <= wreg << OCT_W;
      rem  <= rem - RW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      fidx   <= '0;
    end else if (move) begin
      bvalid <= last;
      fidx   <= last ? '0 : slot + LIW'(1);
    end else if (bvalid && out_ready && !hold) begin
      bvalid <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES_MAX; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                       beat[g] <= '0;
      else if (move && slot == LIW'(g)) beat[g] <= wreg[WORD_MAX-1 -: OCT_W];
    end
    assign out_data[g*OCT_W +: OCT_W] = beat[g];
  end
endmodule

// File: rtl/jtp_sample_packer.sv
module jtp_sample_packer
  import jtp_pkg::*;
#(
  parameter int unsigned WORD_MAX  = P_WORD_MAX,
  parameter int unsigned OCT_W     = P_OCT_W,
  parameter int unsigned LANES_MAX = P_LANES_MAX,
  parameter int unsigned CTRL_MAX  = P_CTRL_MAX,
  parameter int unsigned PRBS_W    = P_PRBS_W,
  parameter int unsigned NW        = $clog2(WORD_MAX + 1),
  parameter int unsigned CW        = $clog2(CTRL_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NW-1:0]              cfg_n,
  input  logic                       cfg_np16,
  input  logic [CW-1:0]              cfg_cs,
  input  logic [1:0]                 cfg_lane_sel,
  input  logic                       cfg_tail_en,
  input  logic                       cfg_test_en,
  input  logic [WORD_MAX-1:0]        cfg_test_pat,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WORD_MAX-1:0]        in_sample,
  input  logic [CTRL_MAX-1:0]        in_ctrl,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [LANES_MAX*OCT_W-1:0] out_data,
  output logic                       cfg_err
);
  localparam int unsigned RW  = $clog2(WORD_MAX / OCT_W + 1);
  localparam int unsigned LCW = $clog2(LANES_MAX + 1);

  logic [PRBS_W-1:0]   prbs;
  logic [WORD_MAX-1:0] word;
  logic [LCW-1:0]      lanes;
  logic [RW-1:0]       n_oct;
  logic [NW:0]         used, np_v;
  logic                take;

  always_comb begin
    lanes   = LCW'(lane_count(cfg_lane_sel));
    n_oct   = cfg_np16 ? RW'(2) : RW'(1);
    np_v    = cfg_np16 ? (NW+1)'(2 * OCT_W) : (NW+1)'(OCT_W);
    used    = (NW+1)'(cfg_n) + (NW+1)'(cfg_cs);
    cfg_err = (cfg_n == '0) || (used > np_v) || (lanes == '0);
    take    = in_valid && in_ready;
  end

  jtp_prbs #(.W(PRBS_W)) u_prbs (
    .clk(clk), .rst_n(rst_n), .step(take), .state(prbs)
  );

  jtp_word_fmt #(
    .WORD_MAX(WORD_MAX), .OCT_W(OCT_W), .CTRL_MAX(CTRL_MAX),
    .PRBS_W(PRBS_W), .NW(NW), .CW(CW)
  ) u_fmt (
    .sample(in_sample), .pat(cfg_test_pat), .test_en(cfg_test_en),
    .ctrl(in_ctrl), .n(cfg_n), .np16(cfg_np16), .cs(cfg_cs),
    .tail_en(cfg_tail_en), .prbs(prbs), .word(word)
  );

  jtp_lane_dist #(
    .WORD_MAX(WORD_MAX), .OCT_W(OCT_W), .LANES_MAX(LANES_MAX),
    .RW(RW), .LCW(LCW)
  ) u_dist (
    .clk(clk), .rst_n(rst_n), .hold(cfg_err), .n_oct(n_oct),
    .lanes(lanes), .word_valid(in_valid), .word_ready(in_ready),
    .word(word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );
endmodule

// File: rtl/jtp_sample_packer_chk.sv
module jtp_sample_packer_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned OCT_W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_err,
  input logic [1:0]    cfg_lane_sel,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  AST_ERR_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !in_ready);                                        // R7
  AST_ERR_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid);                                       // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_err) |=> (out_valid && $stable(out_data))); // R8
  AST_ONE_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_lane_sel == 2'd0) |-> (out_data[DW-1:OCT_W] == '0)); // R6
  AST_TWO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_lane_sel == 2'd1) |-> (out_data[DW-1:2*OCT_W] == '0)); // R6
endmodule

bind jtp_sample_packer jtp_sample_packer_chk #(
  .DW(LANES_MAX * OCT_W), .OCT_W(OCT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .cfg_lane_sel(cfg_lane_sel),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/jtp_sample_packer_tb.sv
module jtp_sample_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_n = 5'd14;
  logic        cfg_np16 = 1'b1;
  logic [1:0]  cfg_cs = 2'd1;
  logic [1:0]  cfg_lane_sel = 2'd0;
  logic        cfg_tail_en = 1'b0;
  logic        cfg_test_en = 1'b0;
  logic [15:0] cfg_test_pat = 16'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = 16'h0;
  logic [2:0]  in_ctrl = 3'h0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        cfg_err;

  always #5 clk = ~clk;

  jtp_sample_packer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .cfg_np16(cfg_np16),
    .cfg_cs(cfg_cs), .cfg_lane_sel(cfg_lane_sel), .cfg_tail_en(cfg_tail_en),
    .cfg_test_en(cfg_test_en), .cfg_test_pat(cfg_test_pat),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .in_ctrl(in_ctrl), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_err(cfg_err)
  );

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  int          lfsr_m;
  int          q[$];
  bit          held;
  logic [31:0] held_data;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // R1 R2 R3 R4 R5: behavioural word model, octets queued MSB first
  task automatic model_push(input int s, input int c);
    int np, t, w, sf;
    np = cfg_np16 ? 16 : 8;
    t  = np - int'(cfg_n) - int'(cfg_cs);
    sf = (cfg_test_en ? int'(cfg_test_pat) : s) & ((1 << cfg_n) - 1);
    w  = (sf << (np - int'(cfg_n))) | ((c >> (3 - int'(cfg_cs))) << t);
    if (cfg_tail_en) w = w | (lfsr_m & ((1 << t) - 1));
    if (cfg_np16) q.push_back((w >> 8) & 255);
    q.push_back(w & 255);
    lfsr_m = ((lfsr_m << 1) | (((lfsr_m >> 14) ^ (lfsr_m >> 13)) & 1)) & 32'h7FFF;
  endtask

  function automatic int nlanes();
    return (cfg_lane_sel == 2'd0) ? 1 : (cfg_lane_sel == 2'd1) ? 2 : 4;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lfsr_m = 32'h7FFF;
    q.delete();
    held = 1'b0;
    #1;
  endtask

  // one falling-edge step: check hold, drive, then account for next edge
  task automatic step(input bit drive, input int rdy_pct);
    @(negedge clk);
    if (held) begin
      chk(out_valid === 1'b1, "R8 stall valid", out_valid, 1);
      chk(out_data === held_data, "R8 stall data", out_data, held_data);
    end
    in_valid  = drive && ($urandom_range(0, 99) < 80);
    in_sample = 16'($urandom);
    in_ctrl   = 3'($urandom);
    out_ready = ($urandom_range(0, 99) < rdy_pct);
    #1;
    chk(cfg_err === 1'b0, "R7 valid cfg", cfg_err, 0);
    held = 1'b0;
    if (out_valid && out_ready) begin
      for (int k = 0; k < 4; k++) begin
        int e;
        if (k < nlanes()) e = (q.size() > 0) ? q.pop_front() : -1;
        else e = 0;
        chk(int'(out_data[k*8 +: 8]) == e, "R6 lane octet", out_data[k*8 +: 8], e);
      end
    end else if (out_valid) begin
      held = 1'b1;
      held_data = out_data;
    end
    if (in_valid && in_ready) model_push(int'(in_sample), int'(in_ctrl));
  endtask

  task automatic run(input int n, input bit np16, input int cs, input int lsel,
                     input bit tail, input bit tst, input int pat, input int cnt,
                     input int rdy_pct);
    int sent, guard;
    cfg_n = 5'(n); cfg_np16 = np16; cfg_cs = 2'(cs); cfg_lane_sel = 2'(lsel);
    cfg_tail_en = tail; cfg_test_en = tst; cfg_test_pat = 16'(pat);
    do_reset();
    chk(out_valid === 1'b0, "R10 reset valid", out_valid, 0);
    chk(out_data === 32'h0, "R10 reset data", out_data, 0);
    chk(in_ready === 1'b1, "R10 reset ready", in_ready, 1);
    sent = 0; guard = 0;
    while (sent < cnt) begin
      step(1'b1, rdy_pct);
      if (in_valid && in_ready) sent++;
    end
    while ((q.size() > 0 || out_valid) && guard < 2000) begin
      step(1'b0, rdy_pct);
      guard++;
    end
    chk(q.size() == 0, "R8 drained", q.size(), 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    // R9 latency probe plus R1 example layout: N=14, N'=16, CS=1, one lane
    cfg_n = 5'd14; cfg_np16 = 1'b1; cfg_cs = 2'd1; cfg_lane_sel = 2'd0;
    cfg_tail_en = 1'b0; cfg_test_en = 1'b0;
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_sample = 16'h2ABC; in_ctrl = 3'b100; out_ready = 1'b0;
    #1;
    chk(in_ready === 1'b1, "R9 accept", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid === 1'b0, "R9 one edge", out_valid, 0);
    @(negedge clk);
    #1;
    chk(out_valid === 1'b1, "R9 two edges", out_valid, 1);
    chk(out_data[7:0] === 8'hAA, "R1 first octet", out_data[7:0], 8'hAA);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    @(negedge clk);
    #1;
    chk(out_valid === 1'b1, "R1 second beat", out_valid, 1);
    chk(out_data[7:0] === 8'hF2, "R1 second octet", out_data[7:0], 8'hF2);
    @(negedge clk);
    out_ready = 1'b0;

    // R7 rejected configurations
    cfg_n = 5'd15; cfg_cs = 2'd2; cfg_np16 = 1'b1; cfg_lane_sel = 2'd0;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b1;
      #1;
      chk(cfg_err === 1'b1, "R7 N+CS over", cfg_err, 1);
      chk(in_ready === 1'b0, "R7 in blocked", in_ready, 0);
      chk(out_valid === 1'b0, "R7 out blocked", out_valid, 0);
    end
    cfg_n = 5'd8; cfg_cs = 2'd0; cfg_lane_sel = 2'd3;
    #1;
    chk(cfg_err === 1'b1, "R7 lane code 3", cfg_err, 1);
    cfg_lane_sel = 2'd0; cfg_n = 5'd0;
    #1;
    chk(cfg_err === 1'b1, "R7 N zero", cfg_err, 1);
    cfg_n = 5'd16; cfg_np16 = 1'b1;
    #1;
    chk(cfg_err === 1'b0, "R7 N equals word", cfg_err, 0);

    // streams: R1 R2 R3 R4 R5 R6 R8
    run(14, 1'b1, 1, 0, 1'b0, 1'b0, 0,       20, 70);  // R1 R2
    run(12, 1'b1, 2, 1, 1'b1, 1'b0, 0,       20, 60);  // R2 R3 R6
    run(8,  1'b0, 0, 2, 1'b0, 1'b1, 16'hA5C3, 24, 50); // R4 R5 R6
    run(6,  1'b0, 2, 1, 1'b1, 1'b0, 0,       20, 40);  // R3 R5
    run(16, 1'b1, 0, 2, 1'b1, 1'b0, 0,       20, 90);  // R6 R8
    run(5,  1'b1, 3, 0, 1'b1, 1'b0, 0,       20, 30);  // R2 R3 R8
    summary();
  end
endmodule